// File: doc/BRIEF.md
# DRAM Address Multiplexer and Refresh Controller

This block sits between a synchronous bus master and an array of four banks of asynchronous DRAM. It holds an 18-bit word address and a 2-bit bank number in on-chip latches. It then places the two 9-bit halves of the address on a shared address bus, row half first and column half second. The bank number selects the one row strobe that fires. A column strobe follows once the bus carries the column half.

Refresh uses the same address bus. A 9-bit refresh counter replaces the row and column halves, and all four row strobes fire together while the column strobe stays off, so every bank is refreshed at once. Two mode pins set how each kind of cycle is timed. With access timing automatic, the block paces the row-to-column switch and the column strobe by itself; with it external, the master drives the mux select and the column strobe directly. With refresh timing automatic, a one-clock request starts a refresh of fixed length; with it external, the refresh lasts for as long as the request stays high. When the address inputs stay valid for the whole access, the latches can be left transparent.

Top module: `dram_mux_ctrl`

## Requirements
- R1: From reset, all four `ras_n` and `cas_n` are high. The refresh counter starts at 0, so the first refresh drives 0 on `ma`.
- R2: With `auto_access`=1, `ras_req` sampled high at an edge starts an access. For the next ROW_CLKS cycles `ma` carries the row half `addr[8:0]`. After that it carries the column half `addr[17:9]`. `cas_n` falls CAS_DLY cycles after the switch to the column half. The access ends on the cycle after `ras_req` is sampled low, and `ras_n` and `cas_n` then return high.
- R3: During an access only `ras_n[b]` is low, where b is the unsigned value of the bank number (0 to 3). The other three stay high.
- R4: With `auto_access`=0, the access is held open while `ras_req` stays high. During that time `ma` shows the column half when `col_sel`=1 and the row half when it is 0, and `cas_n` is the inverse of `cas_in`.
- R5: With `auto_refresh`=1, a high `rfsh_req` sampled while idle starts a refresh on the next cycle. For RFSH_CLKS cycles all four `ras_n` are low, `cas_n` is high and `ma` equals the refresh counter.
- R6: With `auto_refresh`=0, a refresh lasts while `rfsh_req` stays high and ends on the cycle after it is sampled low.
- R7: The refresh counter advances by one when a refresh finishes, not when it starts. It wraps from 511 to 0.
- R8: A refresh request that arrives during an access, or at the same edge as an access request while idle, waits. The refresh starts on the second cycle after the access ends.
- R9: While `latch_en`=1 the address and bank latches are transparent, so the outputs follow `addr_in` and `bank_in` at once. While `latch_en`=0 they hold the values present at the last edge that saw `latch_en`=1. While idle, `ma` shows the row half of the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_access | input | 1 | 1: automatic access timing, 0: external |
| auto_refresh | input | 1 | 1: automatic refresh timing, 0: external |
| latch_en | input | 1 | Address/bank latch enable (1 = transparent) |
| addr_in | input | 18 | Column half in [17:9], row half in [8:0] |
| bank_in | input | 2 | Bank number |
| ras_req | input | 1 | Access request (row strobe in) |
| col_sel | input | 1 | External mode: selects the column half |
| cas_in | input | 1 | External mode: column strobe request |
| rfsh_req | input | 1 | Refresh request |
| ma | output | 9 | Multiplexed DRAM address |
| ras_n | output | 4 | Active-low row strobes, one per bank |
| cas_n | output | 1 | Active-low column strobe |

## Verification
A phase timer that is off by one shows up in the first access: the column half reaches `ma` a cycle early or late, or `cas_n` falls in the wrong cycle. A bad bank decode or a stuck state shows at once as the wrong number of low row strobes. A refresh counter that advances at the wrong moment, or fails to wrap, is seen on `ma` only at the next refresh. This is why the bench runs consecutive refreshes and one full pass of the counter. A request that gets lost or fires early shows one or two cycles after the access ends.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2,
    ST_RFSH = 2'd3
  } dmx_state_e;
endpackage

// File: rtl/dmx_addr_latch.sv
module dmx_addr_latch #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] hold_q, hold_d;

  always_comb hold_d = en ? d : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // fall-through while enabled, stored value otherwise
  assign q = en ? d : hold_q;

  // R9
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en ##1 !en) |-> (q == $past(d)));
endmodule

// File: rtl/dmx_rfsh_cnt.sv
module dmx_rfsh_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = inc ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7
  cnt_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int ROW_CLKS  = 2,
  parameter int CAS_DLY   = 1,
  parameter int RFSH_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_access,
  input  logic auto_refresh,
  input  logic ras_req,
  input  logic rfsh_req,
  output logic acc_act,
  output logic col_phase,
  output logic cas_auto,
  output logic rfsh_act,
  output logic rfsh_done
);
  localparam int TMAX1 = (ROW_CLKS > CAS_DLY + 1) ? ROW_CLKS : CAS_DLY + 1;
  localparam int TMAX  = (TMAX1 > RFSH_CLKS) ? TMAX1 : RFSH_CLKS;
  localparam int TW    = $clog2(TMAX + 1);

  dmx_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          rf_go, rf_start, rf_end;

  always_comb begin
    rf_go    = auto_refresh ? (pend_q | rfsh_req) : rfsh_req;
    rf_end   = auto_refresh ? (tmr_q == TW'(RFSH_CLKS - 1)) : !rfsh_req;
    st_d     = st_q;
    tmr_d    = tmr_q;
    rf_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (ras_req)    st_d = ST_ROW;
        else if (rf_go) begin
          st_d     = ST_RFSH;
          rf_start = 1'b1;
        end
      end
      ST_ROW: begin
        if (!ras_req) st_d = ST_IDLE;
        else if (auto_access) begin
          if (tmr_q == TW'(ROW_CLKS - 1)) begin
            st_d  = ST_COL;
            tmr_d = '0;
          end else tmr_d = tmr_q + 1'b1;
        end
      end
      ST_COL: begin
        if (!ras_req) st_d = ST_IDLE;
        else if (tmr_q < TW'(CAS_DLY)) tmr_d = tmr_q + 1'b1;
      end
      default: begin
        if (rf_end) st_d = ST_IDLE;
        else if (auto_refresh) tmr_d = tmr_q + 1'b1;
      end
    endcase
    pend_d = (pend_q | (auto_refresh & rfsh_req)) & ~rf_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end

  assign acc_act   = (st_q == ST_ROW) || (st_q == ST_COL);
  assign col_phase = (st_q == ST_COL);
  assign cas_auto  = (st_q == ST_COL) && (tmr_q == TW'(CAS_DLY));
  assign rfsh_act  = (st_q == ST_RFSH);
  assign rfsh_done = (st_q == ST_RFSH) && rf_end;

  // R2
  col_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COL) |-> ($past(st_q) == ST_ROW || $past(st_q) == ST_COL));

  // R8
  rfsh_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RFSH) |-> ($past(st_q) == ST_RFSH || $past(st_q) == ST_IDLE));

  // R6
  ext_rfsh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RFSH && !auto_refresh && rfsh_req) |=> (st_q == ST_RFSH));
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int MA_W      = 9,
  parameter int BANKS     = 4,
  parameter int ROW_CLKS  = 2,
  parameter int CAS_DLY   = 1,
  parameter int RFSH_CLKS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     auto_access,
  input  logic                     auto_refresh,
  input  logic                     latch_en,
  input  logic [2*MA_W-1:0]        addr_in,
  input  logic [$clog2(BANKS)-1:0] bank_in,
  input  logic                     ras_req,
  input  logic                     col_sel,
  input  logic                     cas_in,
  input  logic                     rfsh_req,
  output logic [MA_W-1:0]          ma,
  output logic [BANKS-1:0]         ras_n,
  output logic                     cas_n
);
  localparam int BW = $clog2(BANKS);
  localparam int AW = 2 * MA_W;
  localparam int LW = AW + BW;

  logic          rst_s1, sys_rst_n;
  logic [LW-1:0] lat_q;
  logic [AW-1:0] addr_l;
  logic [BW-1:0] bank_l;
  logic [MA_W-1:0] rcnt;
  logic acc_act, col_phase, cas_auto, rfsh_act, rfsh_done, use_col;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      sys_rst_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      sys_rst_n <= rst_s1;
    end
  end

  dmx_addr_latch #(.W(LW)) u_latch (
    .clk(clk), .rst_n(sys_rst_n), .en(latch_en),
    .d({bank_in, addr_in}), .q(lat_q)
  );
  assign addr_l = lat_q[AW-1:0];
  assign bank_l = lat_q[LW-1:AW];

  dmx_rfsh_cnt #(.W(MA_W)) u_rcnt (
    .clk(clk), .rst_n(sys_rst_n), .inc(rfsh_done), .cnt(rcnt)
  );

  dmx_seq #(.ROW_CLKS(ROW_CLKS), .CAS_DLY(CAS_DLY), .RFSH_CLKS(RFSH_CLKS)) u_seq (
    .clk(clk), .rst_n(sys_rst_n), .auto_access(auto_access),
    .auto_refresh(auto_refresh), .ras_req(ras_req), .rfsh_req(rfsh_req),
    .acc_act(acc_act), .col_phase(col_phase), .cas_auto(cas_auto),
    .rfsh_act(rfsh_act), .rfsh_done(rfsh_done)
  );

  assign use_col = acc_act && (auto_access ? col_phase : col_sel);

  always_comb begin
    if (rfsh_act)     ma = rcnt;
    else if (use_col) ma = addr_l[AW-1:MA_W];
    else              ma = addr_l[MA_W-1:0];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    assign ras_n[b] = ~(rfsh_act | (acc_act & (bank_l == BW'(b))));
  end

  assign cas_n = ~(acc_act & (auto_access ? cas_auto : cas_in));

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    acc_act |-> ($countones(~ras_n) == 1));

  // R5
  rfsh_no_cas_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (ras_n == '0) |-> cas_n);
endmodule

// File: tb/dram_mux_ctrl_test.sv
module dram_mux_ctrl_test;
  localparam int ROW_CLKS  = 2;
  localparam int CAS_DLY   = 1;
  localparam int RFSH_CLKS = 3;

  logic clk = 1'b0;
  logic rst_n, auto_access, auto_refresh, latch_en, ras_req, col_sel, cas_in, rfsh_req;
  logic [17:0] addr_in;
  logic [1:0]  bank_in;
  logic [8:0]  ma;
  logic [3:0]  ras_n;
  logic        cas_n;

  int total = 0;
  int fails = 0;
  logic [8:0] exp_cnt = '0;

  localparam logic [17:0] V_ADDR [8] = '{18'h1F0A3, 18'h2C355, 18'h0B1FF, 18'h3FE01,
                                         18'h12345, 18'h2ABCD, 18'h05A5A, 18'h3A5C6};
  localparam logic [1:0]  V_BANK [8] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
  localparam logic        V_AUTO [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  always #4 clk = ~clk;

  dram_mux_ctrl uut (
    .clk(clk), .rst_n(rst_n), .auto_access(auto_access), .auto_refresh(auto_refresh),
    .latch_en(latch_en), .addr_in(addr_in), .bank_in(bank_in), .ras_req(ras_req),
    .col_sel(col_sel), .cas_in(cas_in), .rfsh_req(rfsh_req),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n)
  );

  task automatic chk(input string tag, input logic [8:0] ema, input logic [3:0] eras,
                     input logic ecas);
    total++;
    if (ma !== ema || ras_n !== eras || cas_n !== ecas) begin
      fails++;
      $display("FAIL %s: ma=%h ras_n=%b cas_n=%b expected ma=%h ras_n=%b cas_n=%b",
               tag, ma, ras_n, cas_n, ema, eras, ecas);
    end
  endtask

  // one access, checked every cycle; R2/R3 in auto mode, R4/R3 in external mode
  task automatic run_access(input logic am, input logic [1:0] bk, input logic [17:0] a);
    logic [3:0] er;
    er = ~(4'b1 << bk);
    @(negedge clk);
    auto_access = am; bank_in = bk; addr_in = a; latch_en = 1'b1;
    col_sel = 1'b0; cas_in = 1'b0; ras_req = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (am) begin
        chk("R2 R3 auto access", (i > ROW_CLKS) ? a[17:9] : a[8:0], er,
            !(i >= ROW_CLKS + 1 + CAS_DLY));
      end else begin
        col_sel = (i > 2); cas_in = (i > 3);
        #1 chk("R4 R3 external access", (i > 2) ? a[17:9] : a[8:0], er, !(i > 3));
      end
    end
    ras_req = 1'b0; col_sel = 1'b0; cas_in = 1'b0;
    @(negedge clk);
    chk("R2 access end", a[8:0], 4'hF, 1'b1);
  endtask

  // automatic refresh pulse; R5/R7
  task automatic auto_rfsh(input string tag);
    @(negedge clk);
    auto_refresh = 1'b1; rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    for (int i = 1; i <= RFSH_CLKS; i++) begin
      if (i > 1) @(negedge clk);
      chk(tag, exp_cnt, 4'h0, 1'b1);
    end
    @(negedge clk);
    chk("R5 refresh end", addr_in[8:0], 4'hF, 1'b1);
    exp_cnt = exp_cnt + 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; auto_access = 1'b1; auto_refresh = 1'b1; latch_en = 1'b1;
    ras_req = 1'b0; col_sel = 1'b0; cas_in = 1'b0; rfsh_req = 1'b0;
    addr_in = '0; bank_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 9'h0, 4'hF, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 9'h0, 4'hF, 1'b1);

    // R1 counter starts at zero, R5 first refresh
    auto_rfsh("R1 R5 first refresh");

    // table walk
    for (int v = 0; v < 8; v++) run_access(V_AUTO[v], V_BANK[v], V_ADDR[v]);

    // R7 increment at completion, consecutive refreshes
    auto_rfsh("R7 second refresh");
    auto_rfsh("R7 third refresh");

    // R6 external refresh held for five cycles
    @(negedge clk);
    auto_refresh = 1'b0; rfsh_req = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R6 external refresh", exp_cnt, 4'h0, 1'b1);
    end
    rfsh_req = 1'b0;
    @(negedge clk);
    chk("R6 external refresh end", addr_in[8:0], 4'hF, 1'b1);
    exp_cnt = exp_cnt + 1'b1;
    auto_rfsh("R7 after external refresh");

    // R8 refresh request during access waits
    @(negedge clk);
    auto_access = 1'b1; auto_refresh = 1'b1; bank_in = 2'd2; addr_in = 18'h2468A; ras_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk("R8 access kept during request", 9'h08A, 4'b1011, 1'b1);
    repeat (3) @(negedge clk);
    ras_req = 1'b0;
    @(negedge clk);
    chk("R8 idle cycle after access", 9'h08A, 4'hF, 1'b1);
    @(negedge clk);
    chk("R8 deferred refresh", exp_cnt, 4'h0, 1'b1);
    repeat (RFSH_CLKS) @(negedge clk);
    chk("R8 deferred refresh end", 9'h08A, 4'hF, 1'b1);
    exp_cnt = exp_cnt + 1'b1;

    // R8 simultaneous requests while idle: access wins
    ras_req = 1'b1; rfsh_req = 1'b1; bank_in = 2'd1;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk("R8 access priority", 9'h08A, 4'b1101, 1'b1);
    repeat (4) @(negedge clk);
    ras_req = 1'b0;
    @(negedge clk);
    chk("R8 idle before refresh", 9'h08A, 4'hF, 1'b1);
    @(negedge clk);
    chk("R8 refresh after priority access", exp_cnt, 4'h0, 1'b1);
    repeat (RFSH_CLKS) @(negedge clk);
    exp_cnt = exp_cnt + 1'b1;

    // R9 latch transparency and hold
    addr_in = 18'h155AA; bank_in = 2'd2; latch_en = 1'b1;
    #1 chk("R9 transparent", 9'h1AA, 4'hF, 1'b1);
    @(negedge clk);
    latch_en = 1'b0; addr_in = 18'h2A955; bank_in = 2'd1;
    #1 chk("R9 hold on input change", 9'h1AA, 4'hF, 1'b1);
    ras_req = 1'b1;
    @(negedge clk);
    chk("R9 R3 held bank used", 9'h1AA, 4'b1011, 1'b1);
    ras_req = 1'b0;
    @(negedge clk);
    latch_en = 1'b1;
    #1 chk("R9 reopen latch", 9'h155, 4'hF, 1'b1);

    // R7 wrap: run refreshes until the counter passes 511
    while (exp_cnt != 9'h1FF) auto_rfsh("R7 counter sweep");
    auto_rfsh("R7 count 511");
    auto_rfsh("R7 wrap to 0");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule